// File: doc/BRIEF.md
# Quarter-Wave Quadrature NCO

This block is a numerically controlled oscillator. On every enabled clock it adds a frequency control word to a phase accumulator. It then turns the accumulator phase into a signed sine sample and a signed cosine sample, which feed an I/Q mixer. The output frequency is `fcw * f_clk / 2^PHASE_W`. With the defaults (`PHASE_W = 7`, `fcw = 45`) and a 200 MHz clock, that is 70.3125 MHz. The accumulator is never truncated: every phase bit takes part in the lookup. Spectral purity therefore depends only on the amplitude width, which defaults to 12 bits.

Only one quarter of a sine period is stored, as a table of `2^(PHASE_W-2)` magnitudes. The table is computed while the design elaborates. Both channels read it through two ports, and each rebuilds the full wave from the two top phase bits. The cosine channel reads the same accumulator phase advanced by a quarter turn. The table holds the sine at half-step positions, `sin(2*pi*(a+0.5)/2^PHASE_W)`. Because of that offset, complementing the index mirrors the wave exactly and negating it gives an exact odd half-wave. Sample `p` therefore carries a phase offset of half a step.

Top module: `nco_quadrature`

## Requirements
- R1: While reset is high and in the cycle after it is released, `valid_o` is 0 and `sin_o` and `cos_o` are 0. Reset also returns the phase accumulator to 0.
- R2: Each cycle with `en_i` high adds `fcw_i` to the phase, modulo `2^PHASE_W`. The k-th enabled sample after reset therefore uses phase `k*fcw` modulo `2^PHASE_W`, counting from k = 0.
- R3: For phase `p`, `sin_o` equals `round(A*sin(2*pi*(p+0.5)/2^PHASE_W))` within one LSB, where `A = 2^(AMP_W-1)-1`. The output is two's complement.
- R4: For phase `p`, `cos_o` equals `round(A*cos(2*pi*(p+0.5)/2^PHASE_W))` within one LSB. This is exactly the sine value at phase `p + 2^(PHASE_W-2)`.
- R5: Phase bit `PHASE_W-1` selects a negative output. Phase bit `PHASE_W-2` complements the low `PHASE_W-2` index bits. Two consequences follow, and both hold exactly: the sine at `p + 2^(PHASE_W-1)` is the negated sine at `p`, and the sine at `2^(PHASE_W-1)-1-p` equals the sine at `p`.
- R6: `valid_o` is high exactly two clocks after a clock edge at which `en_i` was high. The sample it marks belongs to the phase held in the accumulator at that edge.
- R7: A cycle with `en_i` low does not advance the phase and produces no sample. Two clocks later `valid_o` is low, and `sin_o` and `cos_o` keep the last valid sample.
- R8: Every valid sample lies within `[-A, A]`. `sin_o^2 + cos_o^2` stays within `2A` of `A^2`.
- R9: Any control word is accepted, including 0 and words at or above `2^(PHASE_W-1)`. Word 0 repeats one sample. `2^PHASE_W - 1` steps the phase backwards.
- R10: The first sample after reset uses phase 0. It is the smallest positive sine value and a cosine within one LSB of `A`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance the phase and issue one sample |
| fcw_i | input | PHASE_W | Frequency control word (phase increment) |
| sin_o | output | AMP_W | Signed sine sample |
| cos_o | output | AMP_W | Signed cosine sample |
| valid_o | output | 1 | Marks a new sample on sin_o/cos_o |

## Verification
Every sample is due two clock edges after the edge that sampled `en_i` high. The first register is the table read and the second is the sign correction. The accumulator advances at the same first edge. The bench drives `en_i` and `fcw_i` on falling edges and keeps a history of the enables and phases it applied. At each later falling edge it compares the outputs with the entry from two falling edges earlier. When that entry was an idle cycle, it checks that the outputs held their last values. The symmetry checks use samples taken across a full period with a control word of 1.

// File: rtl/nco_pkg.sv
package nco_pkg;

   // fixed-point scale used while building the table at elaboration
   localparam int     FRAC_BITS = 28;
   // 2*pi scaled by 2^FRAC_BITS
   localparam longint TWO_PI_Q  = 64'sd1686629713;
   localparam int     SERIES_TERMS = 7;

   // magnitude of the sine at half-step position idx of a 2^phase_w period,
   // scaled to 2^(amp_w-1)-1 and rounded; idx lies in the first quarter
   function automatic longint quarter_sine(input int idx, input int phase_w,
                                           input int amp_w);
      longint x;
      longint x2;
      longint term;
      longint sum;
      longint peak;
      longint denom;
      denom = longint'(2) << phase_w;
      x     = (TWO_PI_Q * longint'(2 * idx + 1)) / denom;
      x2    = (x * x) >>> FRAC_BITS;
      term  = x;
      sum   = x;
      for (int k = 1; k <= SERIES_TERMS; k++) begin
         term = -((term * x2) >>> FRAC_BITS) / longint'((2 * k) * (2 * k + 1));
         sum  = sum + term;
      end
      peak = (longint'(1) << (amp_w - 1)) - 1;
      return (sum * peak + (longint'(1) << (FRAC_BITS - 1))) >>> FRAC_BITS;
   endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int PHASE_W = 7
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   input  logic [PHASE_W-1:0] fcw,
   output logic [PHASE_W-1:0] phase
);

   always_ff @(posedge clk) begin
      if (rst)
         phase <= '0;
      else if (en)
         phase <= phase + fcw;
   end

   // R7
   phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(phase));

   // R2
   phase_step_chk: assert property (@(posedge clk) disable iff (rst)
      en |=> (PHASE_W'(phase - $past(phase)) == $past(fcw)));

endmodule

// File: rtl/nco_quadrant_map.sv
module nco_quadrant_map #(
   parameter int PHASE_W = 7
) (
   input  logic [PHASE_W-1:0] phase,
   output logic [PHASE_W-3:0] addr,
   output logic               neg
);

   localparam int IDX_W = PHASE_W - 2;

   logic [IDX_W-1:0] idx;
   logic             falling;

   always_comb begin
      idx     = phase[IDX_W-1:0];
      falling = phase[PHASE_W-2];
      neg     = phase[PHASE_W-1];
      addr    = falling ? ~idx : idx;
   end

endmodule

// File: rtl/nco_quarter_rom.sv
module nco_quarter_rom #(
   parameter int PHASE_W = 7,
   parameter int AMP_W   = 12,
   parameter int PORTS   = 2
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              load,
   input  logic [PORTS-1:0][PHASE_W-3:0]     addr,
   output logic [PORTS-1:0][AMP_W-2:0]       mag
);

   import nco_pkg::*;

   localparam int ADDR_W = PHASE_W - 2;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int MAG_W  = AMP_W - 1;

   logic [MAG_W-1:0] table_w [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      assign table_w[g] = MAG_W'(quarter_sine(g, PHASE_W, AMP_W));
   end

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      always_ff @(posedge clk) begin
         if (rst)
            mag[p] <= '0;
         else if (load)
            mag[p] <= table_w[addr[p]];
      end
   end

endmodule

// File: rtl/nco_sign_stage.sv
module nco_sign_stage #(
   parameter int AMP_W = 12
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    load,
   input  logic [AMP_W-2:0]        mag,
   input  logic                    neg,
   output logic signed [AMP_W-1:0] sample
);

   logic signed [AMP_W-1:0] pos_val;

   assign pos_val = $signed({1'b0, mag});

   always_ff @(posedge clk) begin
      if (rst)
         sample <= '0;
      else if (load)
         sample <= neg ? -pos_val : pos_val;
   end

   // R5
   sign_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (load && !neg) |=> (sample >= 0));

endmodule

// File: rtl/nco_quadrature.sv
module nco_quadrature #(
   parameter int PHASE_W = 7,
   parameter int AMP_W   = 12
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en_i,
   input  logic [PHASE_W-1:0]      fcw_i,
   output logic signed [AMP_W-1:0] sin_o,
   output logic signed [AMP_W-1:0] cos_o,
   output logic                    valid_o
);

   localparam int CHANNELS = 2;
   localparam int IDX_W    = PHASE_W - 2;
   localparam logic [PHASE_W-1:0] QTR_STEP = PHASE_W'(1) << IDX_W;
   localparam int PEAK     = (1 << (AMP_W - 1)) - 1;
   localparam longint PEAK_SQ  = longint'(PEAK) * longint'(PEAK);
   localparam longint PWR_TOL  = 2 * longint'(PEAK);

   if (PHASE_W < 3 || PHASE_W > 16) begin : g_bad_phase
      $error("nco_quadrature: PHASE_W must lie in 3..16");
   end
   if (AMP_W < 4 || AMP_W > 30) begin : g_bad_amp
      $error("nco_quadrature: AMP_W must lie in 4..30");
   end

   logic [PHASE_W-1:0]                 phase;
   logic [CHANNELS-1:0][IDX_W-1:0]     addr;
   logic [CHANNELS-1:0]                neg_w;
   logic [CHANNELS-1:0]                neg_q;
   logic [CHANNELS-1:0][AMP_W-2:0]     mag;
   logic signed [AMP_W-1:0]            samp [CHANNELS];
   logic                               stage1_v;

   nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
      .clk   (clk),
      .rst   (rst),
      .en    (en_i),
      .fcw   (fcw_i),
      .phase (phase)
   );

   for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
      logic [PHASE_W-1:0] ch_phase;
      if (c == 0) begin : g_sin
         assign ch_phase = phase;
      end else begin : g_cos
         assign ch_phase = phase + QTR_STEP;
      end

      nco_quadrant_map #(.PHASE_W(PHASE_W)) u_map (
         .phase (ch_phase),
         .addr  (addr[c]),
         .neg   (neg_w[c])
      );

      always_ff @(posedge clk) begin
         if (rst)
            neg_q[c] <= 1'b0;
         else if (en_i)
            neg_q[c] <= neg_w[c];
      end

      nco_sign_stage #(.AMP_W(AMP_W)) u_sign (
         .clk    (clk),
         .rst    (rst),
         .load   (stage1_v),
         .mag    (mag[c]),
         .neg    (neg_q[c]),
         .sample (samp[c])
      );
   end

   nco_quarter_rom #(.PHASE_W(PHASE_W), .AMP_W(AMP_W), .PORTS(CHANNELS)) u_rom (
      .clk  (clk),
      .rst  (rst),
      .load (en_i),
      .addr (addr),
      .mag  (mag)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         stage1_v <= 1'b0;
         valid_o  <= 1'b0;
      end else begin
         stage1_v <= en_i;
         valid_o  <= stage1_v;
      end
   end

   assign sin_o = samp[0];
   assign cos_o = samp[1];

   longint pwr;
   assign pwr = longint'(sin_o) * longint'(sin_o) + longint'(cos_o) * longint'(cos_o);

   // R6
   valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
      en_i |=> ##1 valid_o);

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !stage1_v |=> (!valid_o && $stable(sin_o) && $stable(cos_o)));

   // R8
   amp_bound_chk: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> (sin_o >= -PEAK && sin_o <= PEAK && cos_o >= -PEAK && cos_o <= PEAK));

   // R8
   unit_power_chk: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> (pwr >= PEAK_SQ - PWR_TOL && pwr <= PEAK_SQ + PWR_TOL));

endmodule

// File: tb/tb_nco_quadrature.sv
module tb_nco_quadrature;

   localparam int PHASE_W = 7;
   localparam int AMP_W   = 12;
   localparam int NPH     = 1 << PHASE_W;
   localparam int PEAK    = (1 << (AMP_W - 1)) - 1;
   localparam real TWO_PI = 6.283185307179586;

   logic                    clk = 1'b0;
   logic                    rst = 1'b1;
   logic                    en_i = 1'b0;
   logic [PHASE_W-1:0]      fcw_i = '0;
   logic signed [AMP_W-1:0] sin_o;
   logic signed [AMP_W-1:0] cos_o;
   logic                    valid_o;

   int checks = 0;
   int errors = 0;
   int mph = 0;
   int last_s = 0;
   int last_c = 0;
   int ph_hist [0:1023];
   bit en_hist [0:1023];
   int sarr [0:NPH-1];
   int carr [0:NPH-1];

   nco_quadrature #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) dut (
      .clk(clk), .rst(rst), .en_i(en_i), .fcw_i(fcw_i),
      .sin_o(sin_o), .cos_o(cos_o), .valid_o(valid_o)
   );

   always #4 clk = ~clk;

   function automatic int rnd(input real x);
      return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
   endfunction

   function automatic int exp_sin(input int p);
      return rnd(PEAK * $sin(TWO_PI * (real'(p) + 0.5) / NPH));
   endfunction

   function automatic int exp_cos(input int p);
      return rnd(PEAK * $cos(TWO_PI * (real'(p) + 0.5) / NPH));
   endfunction

   task automatic check_eq(input string req, input int act, input int exp_v);
      checks++;
      if (act != exp_v) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
      end
   endtask

   task automatic check_near(input string req, input int act, input int exp_v);
      checks++;
      if (act > exp_v + 1 || act < exp_v - 1) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (+-1)", req, act, exp_v);
      end
   endtask

   // R1: reset state
   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      en_i = 1'b0;
      repeat (3) @(negedge clk);
      check_eq("R1 valid in reset", int'(valid_o), 0);
      check_eq("R1 sine in reset", int'(sin_o), 0);
      check_eq("R1 cosine in reset", int'(cos_o), 0);
      rst = 1'b0;
      mph = 0;
      last_s = 0;
      last_c = 0;
      @(negedge clk);
      check_eq("R1 valid after release", int'(valid_o), 0);
      check_eq("R1 sine after release", int'(sin_o), 0);
   endtask

   // drives n cycles (gap pattern: 0 = always enabled, k>0 = idle every k-th cycle)
   // and checks every output two falling edges after its stimulus (R2, R3, R4, R6, R7)
   task automatic run_seq(input int fcw, input int n, input int gap);
      for (int i = 0; i < n + 2; i++) begin
         if (i >= 2) begin
            check_eq("R6 valid timing", int'(valid_o), int'(en_hist[i-2]));
            if (en_hist[i-2]) begin
               check_near("R3 sine value", int'(sin_o), exp_sin(ph_hist[i-2]));
               check_near("R4 cosine value", int'(cos_o), exp_cos(ph_hist[i-2]));
               sarr[ph_hist[i-2]] = int'(sin_o);
               carr[ph_hist[i-2]] = int'(cos_o);
               last_s = int'(sin_o);
               last_c = int'(cos_o);
            end else begin
               check_eq("R7 sine held while idle", int'(sin_o), last_s);
               check_eq("R7 cosine held while idle", int'(cos_o), last_c);
            end
         end
         en_hist[i] = (i < n) && !(gap > 0 && (i % gap) == gap - 1);
         ph_hist[i] = mph;
         en_i  = en_hist[i];
         fcw_i = PHASE_W'(fcw);
         if (en_hist[i]) mph = (mph + fcw) % NPH;
         @(negedge clk);
      end
      en_i = 1'b0;
   endtask

   // R10: first sample after reset
   task automatic first_sample();
      do_reset();
      run_seq(45, 1, 0);
      check_eq("R10 first sine", last_s, exp_sin(0));
      check_near("R10 first cosine near peak", last_c, PEAK);
      check_eq("R10 first sine positive", int'(last_s > 0), 1);
   endtask

   // R5 and R8: symmetry and bounds over one full period
   task automatic full_period();
      int bad_neg = 0;
      int bad_mir = 0;
      int bad_cos = 0;
      int bad_bnd = 0;
      do_reset();
      run_seq(1, NPH, 0);
      for (int p = 0; p < NPH; p++) begin
         if (sarr[(p + NPH/2) % NPH] != -sarr[p]) bad_neg++;
         if (p < NPH/2 && sarr[NPH/2 - 1 - p] != sarr[p]) bad_mir++;
         if (carr[p] != sarr[(p + NPH/4) % NPH]) bad_cos++;
         if (sarr[p] > PEAK || sarr[p] < -PEAK) bad_bnd++;
         if (sarr[p]*sarr[p] + carr[p]*carr[p] > PEAK*PEAK + 2*PEAK ||
             sarr[p]*sarr[p] + carr[p]*carr[p] < PEAK*PEAK - 2*PEAK) bad_bnd++;
      end
      check_eq("R5 odd half-wave mismatches", bad_neg, 0);
      check_eq("R5 mirrored quadrant mismatches", bad_mir, 0);
      check_eq("R4 cosine vs shifted sine mismatches", bad_cos, 0);
      check_eq("R8 bound violations", bad_bnd, 0);
   endtask

   // R7 and R2: enable gaps keep the phase sequence intact
   task automatic gapped();
      do_reset();
      run_seq(13, 60, 3);
      run_seq(13, 20, 2);
   endtask

   // R9: unusual control words
   task automatic odd_words();
      do_reset();
      run_seq(0, 10, 0);
      check_eq("R9 zero word keeps phase 0", last_s, exp_sin(0));
      run_seq(NPH - 1, 40, 0);
      check_eq("R9 backward phase after 40 steps", mph, (NPH - 40) % NPH);
      run_seq(NPH / 2, 16, 0);
      run_seq(NPH / 2 + 3, 50, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      do_reset();
      first_sample();
      full_period();
      gapped();
      odd_words();
      do_reset();
      run_seq(45, 200, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule